// File: doc/BRIEF.md
# Peripheral Bus Write Splitter

This block sits between an internal bus agent and a slow asynchronous peripheral bus, such as one that serves flash. It takes one write request of one to four bytes through a valid/ready handshake and replays it on the peripheral side as a chain of single-data write transactions. Each transaction is 8 or 16 bits wide, depending on which of two address windows the request falls into. A request is never bursted: every external transaction carries one datum to one address and then closes.

Each window has its own data width, its own number of address-to-data wait cycles and its own number of recovery cycles. Every transaction follows the same phase order. It holds the address for two cycles, then waits, then strobes the data for two cycles, then recovers. A request whose bytes would leave their 4-byte aligned word is refused without any bus activity, and the refusal is recorded in a sticky error flag that software clears.

Top module: `pbs_wr_split`

## Requirements
- R1: `req_ready` is high while the block is idle. A legal request accepted on a clock edge drops `req_ready` from the next cycle. `req_ready` stays low for exactly n·(4+aw+rw) cycles, where n is the number of transfers, and then returns high.
- R2: A request is illegal when `req_len` is 0, or when `req_addr[1:0]` + `req_len` exceeds 4. This includes every length from 5 to 7. An illegal request is consumed in a single cycle. `req_ready` stays high, no strobe goes low, and `sts_err` reads 1 on the following cycle.
- R3: `sts_err` stays set until a cycle with `sts_clr` high clears it. If an illegal request is accepted in that same cycle, the set wins.
- R4: On an 8-bit window a request makes `req_len` transfers, at addresses `req_addr`, `req_addr`+1, and so on. Each transfer drives byte k of `req_data` (bits 8k+7..8k, where k is address bits [1:0]) on `pb_dout[7:0]`, with `pb_dout[15:8]` zero.
- R5: On a 16-bit window a request makes one transfer per halfword it touches. The first address is `req_addr` with bit 0 cleared, and each later address is 2 higher. Each transfer drives halfword h of `req_data` (bits 16h+15..16h, where h is address bit 1) on `pb_dout`.
- R6: `req_addr[24]` selects the window used for a request. Window w takes its width from `cfg_wide[w]` (1 means 16-bit), aw from `cfg_aw[4w+3:4w]` and rw from `cfg_rw[4w+3:4w]`. These values are captured when the request is accepted.
- R7: Counting from the first cycle of a transfer, cycles 0–1 are the address phase. Cycles 2 to 1+aw are the wait phase. The next two cycles are the data phase, and rw recovery cycles follow. The next transfer starts right after the recovery cycles.
- R8: `pb_ce_n` is low during the address, wait and data phases. `pb_we_n` is low only during the two data-phase cycles. `pb_oe_n` is always high. `pb_dout_en` is high from the wait phase through recovery.
- R9: `pb_addr` holds the transfer's address for the whole time `pb_ce_n` is low for that transfer. Each write-enable pulse carries exactly one datum.
- R10: While reset is asserted, `req_ready` reads 1, all three strobes read 1, and `pb_dout_en` and `sts_err` read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block can take a request |
| req_addr | input | 25 | Byte address; bit 24 picks the window |
| req_len | input | 3 | Byte count, legal 1 to 4 |
| req_data | input | 32 | Write data, byte k in lane k of the aligned word |
| cfg_wide | input | 2 | Per-window 16-bit width select |
| cfg_aw | input | 8 | Per-window address-to-data wait count |
| cfg_rw | input | 8 | Per-window recovery count |
| sts_clr | input | 1 | Clears the error flag (write-1-to-clear) |
| sts_err | output | 1 | Sticky alignment error flag |
| pb_addr | output | 25 | Peripheral address |
| pb_dout | output | 16 | Peripheral write data |
| pb_dout_en | output | 1 | Data output driver enable |
| pb_ce_n | output | 1 | Chip enable, active low |
| pb_we_n | output | 1 | Write enable, active low |
| pb_oe_n | output | 1 | Output enable, active low, held high |

## Verification
The assertions assume two things about the inputs. First, the window settings do not change while a request is in flight; this matters less because they are sampled at acceptance. Second, `req_valid` is dropped in the cycle after the handshake completes, so an illegal request that leaves `req_ready` high is not taken twice. The stimulus follows both rules. It changes `cfg_*` only while the block is idle, and it lowers `req_valid` just after the accepting edge. Random requests draw lengths from 0 to 7 and any address offset, so legal and illegal cases are mixed. The bench computes transfer counts, addresses, lane data and phase positions from the width and wait settings it drove itself.

// File: rtl/pbs_pkg.sv
package pbs_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_ADDR,
    PH_WAIT,
    PH_DATA,
    PH_RECV
  } phase_e;

  localparam int unsigned WORD_W = 32;
  localparam int unsigned LANE_W = 16;
  localparam int unsigned LEN_W  = 3;
endpackage

// File: rtl/pbs_plan.sv
module pbs_plan #(
  parameter int unsigned ADDR_W = 25
) (
  input  logic [ADDR_W-1:0]         addr,
  input  logic [pbs_pkg::LEN_W-1:0] len,
  input  logic                      wide,
  output logic                      err,
  output logic [pbs_pkg::LEN_W-1:0] count,
  output logic [ADDR_W-1:0]         first
);
  logic [3:0] span;
  logic       last_half;

  always_comb begin
    span      = {2'b00, addr[1:0]} + {1'b0, len};
    err       = (len == '0) || (span > 4'd4);
    last_half = (span >= 4'd3);
    if (wide) begin
      count = {2'b00, last_half} - {2'b00, addr[1]} + 3'd1;
      first = {addr[ADDR_W-1:1], 1'b0};
    end else begin
      count = len;
      first = addr;
    end
  end
endmodule

// File: rtl/pbs_phase.sv
module pbs_phase
  import pbs_pkg::*;
#(
  parameter int unsigned WAIT_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              more,
  input  logic [WAIT_W-1:0] aw,
  input  logic [WAIT_W-1:0] rw,
  output phase_e            ph_nxt,
  output logic              done
);
  phase_e            ph;
  logic [WAIT_W-1:0] cnt, cnt_n;

  always_comb begin
    ph_nxt = ph;
    cnt_n  = cnt;
    done   = 1'b0;
    unique case (ph)
      PH_IDLE: if (start) begin
        ph_nxt = PH_ADDR;
        cnt_n  = WAIT_W'(1);
      end
      PH_ADDR: if (cnt != '0) cnt_n = cnt - WAIT_W'(1);
        else if (aw == '0) begin
          ph_nxt = PH_DATA;
          cnt_n  = WAIT_W'(1);
        end else begin
          ph_nxt = PH_WAIT;
          cnt_n  = aw - WAIT_W'(1);
        end
      PH_WAIT: if (cnt != '0) cnt_n = cnt - WAIT_W'(1);
        else begin
          ph_nxt = PH_DATA;
          cnt_n  = WAIT_W'(1);
        end
      PH_DATA: if (cnt != '0) cnt_n = cnt - WAIT_W'(1);
        else if (rw != '0) begin
          ph_nxt = PH_RECV;
          cnt_n  = rw - WAIT_W'(1);
        end else done = 1'b1;
      PH_RECV: if (cnt != '0) cnt_n = cnt - WAIT_W'(1);
        else done = 1'b1;
      default: ph_nxt = PH_IDLE;
    endcase
    if (done) begin
      ph_nxt = more ? PH_ADDR : PH_IDLE;
      cnt_n  = WAIT_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph  <= PH_IDLE;
      cnt <= '0;
    end else begin
      ph  <= ph_nxt;
      cnt <= cnt_n;
    end
  end
endmodule

// File: rtl/pbs_lane.sv
module pbs_lane (
  input  logic [1:0]                   off,
  input  logic                         wide,
  input  logic [pbs_pkg::WORD_W-1:0]   word,
  output logic [pbs_pkg::LANE_W-1:0]   lane
);
  always_comb begin
    if (wide) begin
      lane = off[1] ? word[31:16] : word[15:0];
    end else begin
      unique case (off)
        2'd0:    lane = {8'h00, word[7:0]};
        2'd1:    lane = {8'h00, word[15:8]};
        2'd2:    lane = {8'h00, word[23:16]};
        default: lane = {8'h00, word[31:24]};
      endcase
    end
  end
endmodule

// File: rtl/pbs_wr_split.sv
module pbs_wr_split
  import pbs_pkg::*;
#(
  parameter int unsigned ADDR_W  = 25,
  parameter int unsigned WIN_BIT = 24,
  parameter int unsigned WAIT_W  = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic [LEN_W-1:0]    req_len,
  input  logic [WORD_W-1:0]   req_data,
  input  logic [1:0]          cfg_wide,
  input  logic [2*WAIT_W-1:0] cfg_aw,
  input  logic [2*WAIT_W-1:0] cfg_rw,
  input  logic                sts_clr,
  output logic                sts_err,
  output logic [ADDR_W-1:0]   pb_addr,
  output logic [LANE_W-1:0]   pb_dout,
  output logic                pb_dout_en,
  output logic                pb_ce_n,
  output logic                pb_we_n,
  output logic                pb_oe_n
);
  logic              win, win_wide, accept, go, p_err, done, more;
  logic [WAIT_W-1:0] win_aw, win_rw;
  logic [LEN_W-1:0]  p_count;
  logic [ADDR_W-1:0] p_first;
  phase_e            ph_nxt;

  logic [ADDR_W-1:0] cur_q, cur_n;
  logic [LEN_W-1:0]  rem_q, rem_n;
  logic [WORD_W-1:0] dat_q, dat_n;
  logic              wide_q, wide_n;
  logic [WAIT_W-1:0] aw_q, aw_n, rw_q, rw_n;
  logic [LANE_W-1:0] lane_n;

  assign win      = req_addr[WIN_BIT];
  assign win_wide = cfg_wide[win];
  assign win_aw   = win ? cfg_aw[2*WAIT_W-1:WAIT_W] : cfg_aw[WAIT_W-1:0];
  assign win_rw   = win ? cfg_rw[2*WAIT_W-1:WAIT_W] : cfg_rw[WAIT_W-1:0];
  assign accept   = req_valid && req_ready;
  assign go       = accept && !p_err;
  assign more     = (rem_q != '0);

  pbs_plan #(.ADDR_W(ADDR_W)) u_plan (
    .addr (req_addr),
    .len  (req_len),
    .wide (win_wide),
    .err  (p_err),
    .count(p_count),
    .first(p_first)
  );

  pbs_phase #(.WAIT_W(WAIT_W)) u_phase (
    .clk   (clk),
    .rst   (rst),
    .start (go),
    .more  (more),
    .aw    (aw_q),
    .rw    (rw_q),
    .ph_nxt(ph_nxt),
    .done  (done)
  );

  always_comb begin
    cur_n  = cur_q;
    rem_n  = rem_q;
    dat_n  = dat_q;
    wide_n = wide_q;
    aw_n   = aw_q;
    rw_n   = rw_q;
    if (go) begin
      cur_n  = p_first;
      rem_n  = p_count - 3'd1;
      dat_n  = req_data;
      wide_n = win_wide;
      aw_n   = win_aw;
      rw_n   = win_rw;
    end else if (done && more) begin
      cur_n = cur_q + (wide_q ? ADDR_W'(2) : ADDR_W'(1));
      rem_n = rem_q - 3'd1;
    end
  end

  pbs_lane u_lane (
    .off (cur_n[1:0]),
    .wide(wide_n),
    .word(dat_n),
    .lane(lane_n)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_q      <= '0;
      rem_q      <= '0;
      dat_q      <= '0;
      wide_q     <= 1'b0;
      aw_q       <= '0;
      rw_q       <= '0;
      req_ready  <= 1'b1;
      sts_err    <= 1'b0;
      pb_dout    <= '0;
      pb_dout_en <= 1'b0;
      pb_ce_n    <= 1'b1;
      pb_we_n    <= 1'b1;
      pb_oe_n    <= 1'b1;
    end else begin
      cur_q      <= cur_n;
      rem_q      <= rem_n;
      dat_q      <= dat_n;
      wide_q     <= wide_n;
      aw_q       <= aw_n;
      rw_q       <= rw_n;
      req_ready  <= (ph_nxt == PH_IDLE);
      if (accept && p_err) sts_err <= 1'b1;
      else if (sts_clr)    sts_err <= 1'b0;
      pb_dout    <= lane_n;
      pb_dout_en <= (ph_nxt == PH_WAIT) || (ph_nxt == PH_DATA) || (ph_nxt == PH_RECV);
      pb_ce_n    <= !((ph_nxt == PH_ADDR) || (ph_nxt == PH_WAIT) || (ph_nxt == PH_DATA));
      pb_we_n    <= (ph_nxt != PH_DATA);
      pb_oe_n    <= 1'b1;
    end
  end

  assign pb_addr = cur_q;
endmodule

// File: rtl/pbs_checker.sv
module pbs_checker #(
  parameter int unsigned ADDR_W = 25
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_ready,
  input logic [ADDR_W-1:0] req_addr,
  input logic [2:0]        req_len,
  input logic              sts_clr,
  input logic              sts_err,
  input logic              pb_dout_en,
  input logic              pb_ce_n,
  input logic              pb_we_n,
  input logic              pb_oe_n
);
  logic bad_req;
  assign bad_req = req_valid && req_ready &&
                   ((req_len == 3'd0) || (({2'b00, req_addr[1:0]} + {1'b0, req_len}) > 4'd4));

  a_r8_oe_held: assert property (@(posedge clk) disable iff (rst) pb_oe_n);
  a_r8_we_inside_ce: assert property (@(posedge clk) disable iff (rst)
    !pb_we_n |-> (!pb_ce_n && pb_dout_en));
  a_r8_we_two_cycles: assert property (@(posedge clk) disable iff (rst)
    $fell(pb_we_n) |=> !pb_we_n);
  a_r8_we_ends: assert property (@(posedge clk) disable iff (rst)
    (!pb_we_n && $past(!pb_we_n)) |=> pb_we_n);
  a_r1_busy_not_ready: assert property (@(posedge clk) disable iff (rst)
    !pb_ce_n |-> !req_ready);
  a_r8_idle_no_drive: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> !pb_dout_en);
  a_r2_reject_quiet: assert property (@(posedge clk) disable iff (rst)
    bad_req |=> (req_ready && pb_ce_n && pb_we_n && sts_err));
  a_r3_sticky: assert property (@(posedge clk) disable iff (rst)
    (sts_err && !sts_clr) |=> sts_err);
  a_r3_clear: assert property (@(posedge clk) disable iff (rst)
    (sts_clr && !bad_req) |=> !sts_err);
endmodule

bind pbs_wr_split pbs_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_addr  (req_addr),
  .req_len   (req_len),
  .sts_clr   (sts_clr),
  .sts_err   (sts_err),
  .pb_dout_en(pb_dout_en),
  .pb_ce_n   (pb_ce_n),
  .pb_we_n   (pb_we_n),
  .pb_oe_n   (pb_oe_n)
);

// File: tb/test_pbs_wr_split.sv
module test_pbs_wr_split;
  localparam int AW = 25;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [AW-1:0] req_addr = '0;
  logic [2:0]    req_len = 3'd0;
  logic [31:0]   req_data = '0;
  logic [1:0]    cfg_wide = 2'b00;
  logic [7:0]    cfg_aw = 8'h00;
  logic [7:0]    cfg_rw = 8'h00;
  logic          sts_clr = 1'b0;
  logic          sts_err;
  logic [AW-1:0] pb_addr;
  logic [15:0]   pb_dout;
  logic          pb_dout_en, pb_ce_n, pb_we_n, pb_oe_n;

  int  vecs = 0;
  int  fails = 0;
  bit  finished = 1'b0;

  always #2 clk = ~clk;

  pbs_wr_split i_pbs_wr_split (.*);

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    vecs++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int n_xfer(input logic [AW-1:0] a, input int len, input bit w);
    if (!w) return len;
    return ((int'(a[1:0]) + len - 1) / 2) - int'(a[1]) + 1;
  endfunction

  function automatic logic [AW-1:0] x_addr(input logic [AW-1:0] a, input int j, input bit w);
    if (w) return {a[AW-1:1], 1'b0} + AW'(2 * j);
    return a + AW'(j);
  endfunction

  function automatic logic [15:0] x_data(input logic [31:0] d, input logic [AW-1:0] xa, input bit w);
    if (w) return xa[1] ? d[31:16] : d[15:0];
    return {8'h00, d[8*xa[1:0] +: 8]};
  endfunction

  task automatic run_req(input logic [AW-1:0] a, input logic [2:0] len,
                         input logic [31:0] d, input bit clr_too);
    bit w   = cfg_wide[a[24]];
    int aw  = a[24] ? int'(cfg_aw[7:4]) : int'(cfg_aw[3:0]);
    int rw  = a[24] ? int'(cfg_rw[7:4]) : int'(cfg_rw[3:0]);
    bit bad = (len == 3'd0) || (int'(a[1:0]) + int'(len) > 4);
    int n, t;
    @(negedge clk);
    req_addr = a; req_len = len; req_data = d; req_valid = 1'b1; sts_clr = clr_too;
    @(posedge clk);
    #1 req_valid = 1'b0; sts_clr = 1'b0;
    if (bad) begin
      @(negedge clk);
      chk(req_ready == 1'b1, "R2", "ready after reject", req_ready, 1);
      chk(sts_err == 1'b1, clr_too ? "R3" : "R2", "error flag", sts_err, 1);
      for (int k = 0; k < 3; k++) begin
        chk(pb_ce_n && pb_we_n, "R2", "strobes after reject", {pb_ce_n, pb_we_n}, 3);
        @(negedge clk);
      end
      return;
    end
    n = n_xfer(a, int'(len), w);
    t = 4 + aw + rw;
    for (int c = 0; c <= n * t; c++) begin
      @(negedge clk);
      if (c == n * t) begin
        chk(req_ready == 1'b1, "R1", "ready back", req_ready, 1);
        chk(pb_ce_n == 1'b1, "R1", "ce idle at end", pb_ce_n, 1);
      end else begin
        int  j = c / t;
        int  p = c % t;
        bit  e_ce = (p < 4 + aw);
        bit  e_we = (p == 2 + aw) || (p == 3 + aw);
        logic [AW-1:0] ea = x_addr(a, j, w);
        chk(req_ready == 1'b0, "R1", "ready while busy", req_ready, 0);
        chk(pb_ce_n == !e_ce, "R7", "ce_n phase (R6 window)", pb_ce_n, !e_ce);
        chk(pb_we_n == !e_we, "R7", "we_n phase (R6 window)", pb_we_n, !e_we);
        chk(pb_oe_n == 1'b1, "R8", "oe_n", pb_oe_n, 1);
        chk(pb_dout_en == (p >= 2), "R8", "dout_en", pb_dout_en, p >= 2);
        if (e_ce) chk(pb_addr == ea, "R9", "address held", pb_addr, ea);
        if (e_we) chk(pb_dout == x_data(d, ea, w), w ? "R5" : "R4", "lane data",
                      pb_dout, x_data(d, ea, w));
      end
    end
  endtask

  task automatic clear_err();
    @(negedge clk); sts_clr = 1'b1;
    @(posedge clk); #1 sts_clr = 1'b0;
    @(negedge clk);
    chk(sts_err == 1'b0, "R3", "flag cleared", sts_err, 0);
  endtask

  initial begin
    void'($urandom(32'h5eed1234));
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(req_ready == 1'b1, "R10", "reset ready", req_ready, 1);
    chk({pb_ce_n, pb_we_n, pb_oe_n} == 3'b111, "R10", "reset strobes", {pb_ce_n, pb_we_n, pb_oe_n}, 7);
    chk(pb_dout_en == 1'b0, "R10", "reset dout_en", pb_dout_en, 0);
    chk(sts_err == 1'b0, "R10", "reset flag", sts_err, 0);
    rst = 1'b0;

    cfg_wide = 2'b10; cfg_aw = 8'h31; cfg_rw = 8'h02;
    run_req(25'h0000100, 3'd4, 32'hA1B2C3D4, 1'b0);  // R4 aligned word, 8-bit
    run_req(25'h1000200, 3'd4, 32'h11223344, 1'b0);  // R5 aligned word, 16-bit
    run_req(25'h1000201, 3'd1, 32'h55667788, 1'b0);  // R5 odd byte on 16-bit
    run_req(25'h1000201, 3'd2, 32'h99AABBCC, 1'b0);  // R5 straddles halves
    run_req(25'h0000003, 3'd1, 32'hDEADBEEF, 1'b0);  // R4 last lane
    cfg_aw = 8'h00; cfg_rw = 8'h00;
    run_req(25'h0000010, 3'd3, 32'h01020304, 1'b0);  // R7 zero waits
    cfg_aw = 8'hFF; cfg_rw = 8'hFF;
    run_req(25'h1000010, 3'd4, 32'hCAFEF00D, 1'b0);  // R7 max waits
    run_req(25'h0000012, 3'd0, 32'h0, 1'b0);         // R2 zero length
    clear_err();
    run_req(25'h0000013, 3'd2, 32'h0, 1'b0);         // R2 crosses word
    clear_err();
    run_req(25'h0000010, 3'd5, 32'h0, 1'b0);         // R2 too long
    run_req(25'h0000011, 3'd4, 32'h0, 1'b1);         // R3 set beats clear
    clear_err();

    for (int i = 0; i < 150; i++) begin
      logic [AW-1:0] a;
      logic [2:0] len;
      cfg_wide = 2'($urandom);
      cfg_aw = 8'($urandom);
      cfg_rw = 8'($urandom);
      a = AW'($urandom);
      len = ($urandom % 5 == 0) ? 3'($urandom) : 3'(1 + $urandom % (4 - a[1:0]));
      run_req(a, len, $urandom, 1'b0);
      if (sts_err) clear_err();
    end

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL R1 watchdog: got hung expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
      $finish;
    end
  end
endmodule